// File: doc/BRIEF.md
# Prescaled Multi-Channel Timer Bank

A bank of independent counter channels, each with its own small register window on a plain memory-mapped bus. Every channel divides the input clock by a programmable prescaler and counts the resulting ticks up or down. It runs in one of two modes. In free-running mode it wraps at the ends of its range. In periodic mode it restarts from a programmed reload value. Whenever a channel reaches its terminal count it sets a sticky status flag, and the flag can drive a level interrupt. From the same live count, each channel can also produce a pulse-width output by comparing the count against a compare register.

Software cannot clear the live count. A write to the value location changes only the reload register, and a read of that location returns the running count. A channel's count therefore reaches a known value only by counting there, and any stop keeps the count where it was. The edge-source field and two mode bits are held and read back, but they do not change counting.

Top module: `timer_bank`

## Requirements
- R1: After reset every register and count of every channel is 0, `irq` and `pwm_out` are all low, and `rdata` is 0.
- R2: Channel n occupies byte addresses n*0x20 to n*0x20+0x1F. Its registers sit at these offsets: control 0x00, prescaler 0x04, reload/value 0x08, status 0x0C, compare 0x10. Control keeps bits 0-6 and 8-11 and reads 0 elsewhere. Prescaler and compare keep the low 16 bits.
- R3: `rdata` is registered. It shows the addressed register in the cycle after `rd_en` is sampled high, and it is 0 in any cycle after `rd_en` was low.
- R4: Any offset other than the five in R2 reads 0 and ignores writes. This also holds for every offset in a window at or above channel NUM_CH.
- R5: While control bit 0 is set, the count advances once every (prescaler+1) clocks. The first advance comes (prescaler+1) clocks after the enabling write. While bit 0 is clear the prescale phase is held at 0.
- R6: With bit 4 set (up), the count increments. Outside periodic mode it steps from 0xFFFF to 0, and that step is an expiry.
- R7: With bit 4 clear (down), the count decrements. A tick at count 0 is an expiry. It loads the reload value when the mode field (bits 11:10) equals 1, and loads 0xFFFF otherwise.
- R8: Up-counting in periodic mode (mode field 1): a tick while the count equals the reload value sets the count to 0 and is an expiry.
- R9: A write to offset 0x08 changes only the reload value, and a read of 0x08 returns the live count in bits 15:0.
- R10: Clearing bit 0 freezes the count at its current value, and no register write alters the count directly. A running channel leaves the other channels' counts untouched.
- R11: An expiry sets status bit 0. Writing the value 0 to status clears it. A nonzero write leaves it unchanged, and in the same cycle an expiry wins over a clear.
- R12: `irq[n]` is high exactly when channel n's status bit and its control bit 1 are both set.
- R13: `pwm_out[n]` is high when control bits 2 and 3 are both set and the count is below the compare value, and low otherwise. It follows the registers with one clock of delay.
- R14: Control bits 5, 6, 8 and 9 are stored and read back but do not change how the count advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | Read request, data in next cycle |
| addr | input | ADDR_W | Byte address (channel in upper bits, offset in low 5 bits) |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| irq | output | NUM_CH | Per-channel level interrupts |
| pwm_out | output | NUM_CH | Per-channel pulse-width outputs |

## Verification
The bench builds the default configuration: five 16-bit channels with an 8-bit address. Every channel is swept across prescaler settings 0 to 3 and several run lengths. Each expected count comes from tick arithmetic on a count read back first, because the count cannot be reset. The 16-bit boundaries are reached in a few dozen cycles by using a periodic down-count to load a value next to 0xFFFF. The 8-bit address also exposes the three empty windows above channel 4, so the bench can write to them and confirm that nothing changes.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;
  localparam int WIN_W  = 5;
  localparam int CTRL_W = 12;

  localparam logic [WIN_W-1:0] OFS_CTRL = 5'h00;
  localparam logic [WIN_W-1:0] OFS_PSC  = 5'h04;
  localparam logic [WIN_W-1:0] OFS_LOAD = 5'h08;
  localparam logic [WIN_W-1:0] OFS_STAT = 5'h0C;
  localparam logic [WIN_W-1:0] OFS_CMP  = 5'h10;

  localparam int B_EN   = 0;
  localparam int B_IE   = 1;
  localparam int B_OE   = 2;
  localparam int B_PWM  = 3;
  localparam int B_UP   = 4;
  localparam int B_MODE = 10;

  localparam logic [1:0]        MODE_PERIODIC = 2'd1;
  localparam logic [CTRL_W-1:0] CTRL_MASK     = 12'hF7F;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_PSC, SEL_LOAD, SEL_STAT, SEL_CMP
  } reg_sel_e;

  function automatic reg_sel_e decode_offset(input logic [WIN_W-1:0] ofs);
    case (ofs)
      OFS_CTRL: return SEL_CTRL;
      OFS_PSC:  return SEL_PSC;
      OFS_LOAD: return SEL_LOAD;
      OFS_STAT: return SEL_STAT;
      OFS_CMP:  return SEL_CMP;
      default:  return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         tick
);
  logic [W-1:0] phase_q;

  assign tick = run && (phase_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || !run) phase_q <= '0;
    else if (phase_q >= limit) phase_q <= '0;
    else phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/timer_counter.sv
module timer_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         count_up,
  input  logic         periodic,
  input  logic [W-1:0] reload,
  output logic [W-1:0] count,
  output logic         expire
);
  localparam logic [W-1:0] TOP = '1;

  logic at_reload, at_top, at_zero;

  assign at_reload = periodic && (count == reload);
  assign at_top    = (count == TOP);
  assign at_zero   = (count == '0);
  assign expire    = tick && (count_up ? (at_reload || at_top) : at_zero);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (tick) begin
      if (count_up) begin
        if (at_reload || at_top) count <= '0;
        else count <= count + 1'b1;
      end else begin
        if (at_zero) count <= periodic ? reload : TOP;
        else count <= count - 1'b1;
      end
    end
  end
endmodule

// File: rtl/timer_channel.sv
module timer_channel
  import timer_bank_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WIN_W-1:0]  ofs,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_val,
  output logic              irq,
  output logic              pwm
);
  reg_sel_e          sel;
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  psc_q, load_q, cmp_q, count;
  logic              stat_q, pwm_q, tick, expire, periodic;

  assign sel      = decode_offset(ofs);
  assign periodic = (ctrl_q[B_MODE +: 2] == MODE_PERIODIC);

  timer_prescaler #(.W(CNT_W)) u_psc (
    .clk(clk), .rst(rst), .run(ctrl_q[B_EN]), .limit(psc_q), .tick(tick)
  );

  timer_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .count_up(ctrl_q[B_UP]),
    .periodic(periodic), .reload(load_q), .count(count), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      psc_q  <= '0;
      load_q <= '0;
      cmp_q  <= '0;
      stat_q <= 1'b0;
      pwm_q  <= 1'b0;
    end else begin
      if (wr_en && sel == SEL_CTRL) ctrl_q <= wdata[CTRL_W-1:0] & CTRL_MASK;
      if (wr_en && sel == SEL_PSC)  psc_q  <= wdata[CNT_W-1:0];
      if (wr_en && sel == SEL_LOAD) load_q <= wdata[CNT_W-1:0];
      if (wr_en && sel == SEL_CMP)  cmp_q  <= wdata[CNT_W-1:0];
      if (expire) stat_q <= 1'b1;
      else if (wr_en && sel == SEL_STAT && wdata == '0) stat_q <= 1'b0;
      pwm_q <= ctrl_q[B_OE] && ctrl_q[B_PWM] && (count < cmp_q);
    end
  end

  assign irq = stat_q && ctrl_q[B_IE];
  assign pwm = pwm_q;

  always_comb begin
    case (sel)
      SEL_CTRL: rd_val = DATA_W'(ctrl_q);
      SEL_PSC:  rd_val = DATA_W'(psc_q);
      SEL_LOAD: rd_val = DATA_W'(count);
      SEL_STAT: rd_val = DATA_W'(stat_q);
      SEL_CMP:  rd_val = DATA_W'(cmp_q);
      default:  rd_val = '0;
    endcase
  end
endmodule

// File: rtl/timer_bank.sv
module timer_bank
  import timer_bank_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NUM_CH-1:0] irq,
  output logic [NUM_CH-1:0] pwm_out
);
  localparam int CH_W = ADDR_W - WIN_W;

  logic [CH_W-1:0]   ch_idx;
  logic [WIN_W-1:0]  ofs;
  logic [DATA_W-1:0] ch_rd [NUM_CH];
  logic [DATA_W-1:0] rd_mux;

  assign ch_idx = addr[ADDR_W-1:WIN_W];
  assign ofs    = addr[WIN_W-1:0];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    timer_channel #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_ch (
      .clk(clk), .rst(rst),
      .wr_en(wr_en && (ch_idx == CH_W'(g))),
      .ofs(ofs), .wdata(wdata), .rd_val(ch_rd[g]),
      .irq(irq[g]), .pwm(pwm_out[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (ch_idx == CH_W'(i)) rd_mux = ch_rd[i];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
    else rdata <= '0;
  end
endmodule

// File: rtl/timer_bank_chk.sv
module timer_bank_chk
  import timer_bank_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic [NUM_CH-1:0] irq,
  input logic [NUM_CH-1:0] pwm_out
);
  logic mapped;
  assign mapped = (decode_offset(addr[WIN_W-1:0]) != SEL_NONE) &&
                  (int'(addr[ADDR_W-1:WIN_W]) < NUM_CH);

  // R1: outputs quiet after a reset cycle
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (irq == '0 && pwm_out == '0 && rdata == '0));

  // R3: no read request, no data
  a_r3_idle_rdata_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> rdata == '0);

  // R4: unmapped locations read zero
  a_r4_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !mapped) |=> rdata == '0);

  // R11: status reads carry a single bit
  a_r11_status_narrow: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr[WIN_W-1:0] == OFS_STAT) |=> rdata[DATA_W-1:1] == '0);

  // R9: value reads never exceed the counter width
  a_r9_value_narrow: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr[WIN_W-1:0] == OFS_LOAD) |=> rdata[DATA_W-1:CNT_W] == '0);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_irq
    // R12: an interrupt only drops after a register write
    a_r12_irq_drop_by_write: assert property (@(posedge clk) disable iff (rst)
      $fell(irq[g]) |-> $past(wr_en));
  end
endmodule

bind timer_bank timer_bank_chk #(
  .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rdata(rdata), .irq(irq), .pwm_out(pwm_out)
);

// File: tb/timer_bank_tb.sv
module timer_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 5;

  localparam logic [31:0] C_EN  = 32'h001;
  localparam logic [31:0] C_IE  = 32'h002;
  localparam logic [31:0] C_OE  = 32'h004;
  localparam logic [31:0] C_PWM = 32'h008;
  localparam logic [31:0] C_UP  = 32'h010;
  localparam logic [31:0] C_PER = 32'h400;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NCH-1:0] irq, pwm_out;

  int nchk = 0;
  int nfail = 0;
  logic [15:0] ld_m [NCH];

  always #(CLK_PERIOD/2) clk = ~clk;

  timer_bank u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .pwm_out(pwm_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] ra(input int ch, input int ofs);
    return 8'(ch * 32 + ofs);
  endfunction

  function automatic logic [15:0] model(input logic [15:0] c0, input logic [15:0] ld,
                                        input bit up, input bit per, input int ticks,
                                        inout int nexp);
    logic [15:0] c = c0;
    for (int t = 0; t < ticks; t++) begin
      if (up) begin
        if ((per && c == ld) || c == 16'hFFFF) begin c = 16'h0; nexp++; end
        else c = c + 16'd1;
      end else begin
        if (c == 16'h0) begin c = per ? ld : 16'hFFFF; nexp++; end
        else c = c - 16'd1;
      end
    end
    return c;
  endfunction

  // enable for W idle cycles, stop, compare count and status against tick arithmetic
  task automatic run_chk(input int ch, input logic [31:0] cfg, input int psc,
                         input int w, input string req);
    logic [31:0] d;
    logic [15:0] c0, ce;
    int nexp = 0;
    wr(ra(ch, 12), 32'h0);
    rd(ra(ch, 8), d); c0 = d[15:0];
    wr(ra(ch, 4), 32'(psc));
    wr(ra(ch, 0), cfg | C_EN);
    idle(w);
    wr(ra(ch, 0), cfg);
    ce = model(c0, ld_m[ch], cfg[4], cfg[11:10] == 2'd1, (w + 1) / (psc + 1), nexp);
    rd(ra(ch, 8), d);
    chk({req, " count"}, d, {16'h0, ce});
    rd(ra(ch, 12), d);
    chk({req, " R11 status"}, d, (nexp > 0) ? 32'h1 : 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [15:0] c;
    for (int i = 0; i < NCH; i++) ld_m[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 pwm", 32'(pwm_out), 32'h0);
    chk("R1 rdata", rdata, 32'h0);
    for (int ch = 0; ch < NCH; ch++)
      for (int o = 0; o <= 16; o += 4) begin
        rd(ra(ch, o), d);
        chk("R1 register", d, 32'h0);
      end

    // R2 R14: field widths and readback
    for (int ch = 0; ch < NCH; ch++) begin
      wr(ra(ch, 0), 32'hFFFF_FFFE);
      rd(ra(ch, 0), d); chk("R2 R14 control", d, 32'h0000_0F7E);
      wr(ra(ch, 4), 32'h1234_5678);
      rd(ra(ch, 4), d); chk("R2 prescaler", d, 32'h0000_5678);
      wr(ra(ch, 16), 32'hABCD_0042);
      rd(ra(ch, 16), d); chk("R2 compare", d, 32'h0000_0042);
      wr(ra(ch, 0), 32'h0);
      chk("R12 irq idle", 32'(irq), 32'h0);
    end

    // R3: data only follows a read request
    idle(1);
    chk("R3 idle rdata", rdata, 32'h0);

    // R4: holes and missing windows
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'hA4, 32'h0000_0001);
    wr(8'hE0, 32'h0000_0FFF);
    rd(8'h14, d); chk("R4 hole 0x14", d, 32'h0);
    rd(8'h1C, d); chk("R4 hole 0x1C", d, 32'h0);
    rd(8'hA4, d); chk("R4 window 5", d, 32'h0);
    rd(8'hE0, d); chk("R4 window 7", d, 32'h0);
    rd(ra(0, 4), d); chk("R4 ch0 prescaler intact", d, 32'h0000_5678);
    rd(ra(0, 0), d); chk("R4 ch0 control intact", d, 32'h0);

    // R9: reload write does not touch the live count
    wr(ra(0, 8), 32'h0000_0777);
    rd(ra(0, 8), d); chk("R9 value after reload write", d, 32'h0);
    wr(ra(0, 8), 32'h0);

    // R5 R6 R14: up-count sweep over prescaler and run length
    for (int ch = 0; ch < NCH; ch++)
      for (int p = 0; p < 4; p++)
        for (int k = 0; k < 3; k++)
          run_chk(ch, (ch == 4) ? (C_UP | 32'h360) : C_UP, p,
                  (k == 0) ? 3 : ((k == 1) ? 7 : 10), "R5 R6 R14");

    // R10: stopped count holds, other channels untouched
    rd(ra(3, 8), d); c = d[15:0];
    idle(6);
    rd(ra(3, 8), d); chk("R10 held count", d, {16'h0, c});
    run_chk(0, C_UP, 0, 9, "R10 R6");
    rd(ra(3, 8), d); chk("R10 neighbour count", d, {16'h0, c});

    // R7: periodic down reload lands next to the top of range
    wr(ra(2, 8), 32'h0000_FFFD); ld_m[2] = 16'hFFFD;
    rd(ra(2, 8), d);
    run_chk(2, C_PER, 0, int'(d[15:0]), "R7 periodic");
    // R6: wrap from 0xFFFF to 0 is an expiry
    run_chk(2, C_UP, 0, 2, "R6 wrap");
    // R12 R11: interrupt gating and status clearing
    chk("R12 masked", 32'(irq[2]), 32'h0);
    wr(ra(2, 0), C_IE | C_UP);
    chk("R12 enabled", 32'(irq[2]), 32'h1);
    wr(ra(2, 12), 32'h0000_0001);
    rd(ra(2, 12), d); chk("R11 nonzero write keeps", d, 32'h1);
    chk("R12 still high", 32'(irq[2]), 32'h1);
    wr(ra(2, 12), 32'h0);
    rd(ra(2, 12), d); chk("R11 zero write clears", d, 32'h0);
    chk("R12 low after clear", 32'(irq[2]), 32'h0);
    wr(ra(2, 0), 32'h0);

    // R7: free-running down wraps to 0xFFFF
    rd(ra(3, 8), d);
    run_chk(3, 32'h0, 0, int'(d[15:0]) + 1, "R7 free down");

    // R8: up periodic restarts at the reload value
    rd(ra(0, 8), d);
    ld_m[0] = d[15:0] + 16'd3;
    wr(ra(0, 8), {16'h0, ld_m[0]});
    run_chk(0, C_UP | C_PER, 0, 4, "R8");

    // R7 R5: periodic down with a prescaler and several reloads
    wr(ra(1, 8), 32'h4); ld_m[1] = 16'h4;
    run_chk(1, C_PER, 2, 40, "R7 R5");

    // R9: new reload value taken at the next reload
    rd(ra(1, 8), d); c = d[15:0];
    wr(ra(1, 8), 32'h0000_0777); ld_m[1] = 16'h0777;
    rd(ra(1, 8), d); chk("R9 live count kept", d, {16'h0, c});
    run_chk(1, C_PER, 0, int'(c) + 1, "R9 reload");

    // R13: PWM compare on a stopped channel
    rd(ra(4, 8), d); c = d[15:0];
    wr(ra(4, 16), {16'h0, c + 16'd1});
    wr(ra(4, 0), C_OE | C_PWM);
    idle(1);
    chk("R13 below compare", 32'(pwm_out), 32'h10);
    wr(ra(4, 16), {16'h0, c});
    idle(1);
    chk("R13 equal compare", 32'(pwm_out), 32'h0);
    wr(ra(4, 16), {16'h0, c + 16'd1});
    wr(ra(4, 0), C_PWM);
    idle(1);
    chk("R13 output disabled", 32'(pwm_out), 32'h0);
    wr(ra(4, 0), C_OE);
    idle(1);
    chk("R13 pwm off", 32'(pwm_out), 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule